// File: doc/BRIEF.md
# Configurable Multilevel Pipeline Register

This block is a bank of four data registers that share one clock and can be arranged in two ways. A 2-bit operation code chosen on every cycle decides which registers capture on the next rising edge. The four registers can run as a single four-deep delay line. They can also be split into two independent two-deep pipelines: an upper pair fed from the data input, and a lower pair that is also fed from the data input.

A second 2-bit code, independent of the operation code, drives a four-way read multiplexer. The multiplexer can present any register on the output while other registers are being written. The output is three-state under an active-low enable. Data in and data out are separate ports. An optional synchronous reset clears the bank.

Top module: `pipe_bank4`

## Requirements
- R1: While `rst` is high at a rising edge, all four registers become zero on that edge, whatever `op` holds.
- R2: With `op` = 2'b00, one edge moves `din` into stage 1, stage 1 into stage 2, stage 2 into stage 3 and stage 3 into stage 4.
- R3: With `op` = 2'b01, one edge loads `din` into stage 3 and moves stage 3 into stage 4, while stages 1 and 2 keep their values.
- R4: With `op` = 2'b10, one edge loads `din` into stage 1 and moves stage 1 into stage 2, while stages 3 and 4 keep their values.
- R5: With `op` = 2'b11, no register changes on the edge.
- R6: When `oe_n` is low, `rd_sel` picks the register on `dout`: 2'b00 gives stage 4, 2'b01 gives stage 3, 2'b10 gives stage 2 and 2'b11 gives stage 1.
- R7: When `oe_n` is high, every bit of `dout` is high-impedance. When `oe_n` is low, `dout` is driven.
- R8: The read path has no register. A selected register's new value appears on `dout` in the same cycle that follows the edge that wrote it, even when that register is being written on every cycle.
- R9: `rd_sel` and `oe_n` have no effect on register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all registers |
| rst | input | 1 | Synchronous active-high clear of all registers |
| din | input | WIDTH | Data written into stage 1 and/or stage 3 |
| op | input | 2 | Operation code choosing shift, split load or hold |
| rd_sel | input | 2 | Read select for the output multiplexer |
| oe_n | input | 1 | Active-low output enable |
| dout | output | WIDTH | Selected register, or high-impedance |

## Verification
The bench runs long runs of each single operation code, so that a full four-stage shift can be told apart from the two split pipelines and from hold. It then runs pseudo-random mixes that switch the code on every cycle, which exposes mistakes in the source of stage 3 (stage 2 or the input). Separate passes sweep the read select and the output enable during hold, which shows that reading and enable changes leave the contents alone. A reset asserted together with a shift code confirms that reset wins.

// File: rtl/pbank_pkg.sv
package pbank_pkg;

  localparam int NSTAGE = 4;

  typedef enum logic [1:0] {
    OP_SHIFT4 = 2'b00,
    OP_LOWER  = 2'b01,
    OP_UPPER  = 2'b10,
    OP_HOLD   = 2'b11
  } pbank_op_e;

  // Stage index 0..3 stands for stage 1..4.
  function automatic logic stage_loads(input pbank_op_e op, input int idx);
    if (idx < 2) return (op == OP_SHIFT4) || (op == OP_UPPER);
    else         return (op == OP_SHIFT4) || (op == OP_LOWER);
  endfunction

  function automatic logic stage_takes_input(input pbank_op_e op, input int idx);
    if (idx == 0)      return 1'b1;
    else if (idx == 2) return op == OP_LOWER;
    else               return 1'b0;
  endfunction

  // Select code counts down from the last stage.
  function automatic int sel_to_stage(input logic [1:0] sel);
    return (NSTAGE - 1) - int'(sel);
  endfunction

endpackage

// File: rtl/pbank_ctl.sv
module pbank_ctl
  import pbank_pkg::*;
(
  input  logic [1:0]        op,
  output logic [NSTAGE-1:0] load_en,
  output logic [NSTAGE-1:0] from_din
);
  pbank_op_e op_e;
  assign op_e = pbank_op_e'(op);

  for (genvar i = 0; i < NSTAGE; i++) begin : g_dec
    assign load_en[i]  = stage_loads(op_e, i);
    assign from_din[i] = stage_takes_input(op_e, i);
  end
endmodule

// File: rtl/pbank_regs.sv
module pbank_regs
  import pbank_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter bit HAS_RESET = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [WIDTH-1:0]             din,
  input  logic [NSTAGE-1:0]            load_en,
  input  logic [NSTAGE-1:0]            from_din,
  output logic [NSTAGE-1:0][WIDTH-1:0] stage_q
);
  logic [NSTAGE-1:0][WIDTH-1:0] stage_d;

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign stage_d[i] = din;
    end else begin : g_body
      assign stage_d[i] = from_din[i] ? din : stage_q[i-1];
    end

    if (HAS_RESET) begin : g_rst
      always_ff @(posedge clk) begin
        if (rst)             stage_q[i] <= '0;
        else if (load_en[i]) stage_q[i] <= stage_d[i];
      end
    end else begin : g_norst
      logic unused_rst;
      assign unused_rst = rst;
      always_ff @(posedge clk) begin
        if (load_en[i]) stage_q[i] <= stage_d[i];
      end
    end
  end
endmodule

// File: rtl/pbank_rdmux.sv
module pbank_rdmux
  import pbank_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [NSTAGE-1:0][WIDTH-1:0] stage_q,
  input  logic [1:0]                   rd_sel,
  output logic [WIDTH-1:0]             rd_data
);
  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NSTAGE; k++) begin
      if (sel_to_stage(rd_sel) == k) rd_data = stage_q[k];
    end
  end
endmodule

// File: rtl/pipe_bank4.sv
module pipe_bank4
  import pbank_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter bit HAS_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  logic [1:0]       op,
  input  logic [1:0]       rd_sel,
  input  logic             oe_n,
  output logic [WIDTH-1:0] dout
);
  logic [NSTAGE-1:0]            load_en;
  logic [NSTAGE-1:0]            from_din;
  logic [NSTAGE-1:0][WIDTH-1:0] stage_q;
  logic [WIDTH-1:0]             rd_data;

  // Named events for the checks below.
  logic ev_shift4, ev_lower, ev_upper, ev_hold;
  assign ev_shift4 = (op == OP_SHIFT4);
  assign ev_lower  = (op == OP_LOWER);
  assign ev_upper  = (op == OP_UPPER);
  assign ev_hold   = (op == OP_HOLD);

  pbank_ctl u_ctl (
    .op       (op),
    .load_en  (load_en),
    .from_din (from_din)
  );

  pbank_regs #(.WIDTH(WIDTH), .HAS_RESET(HAS_RESET)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .din      (din),
    .load_en  (load_en),
    .from_din (from_din),
    .stage_q  (stage_q)
  );

  pbank_rdmux #(.WIDTH(WIDTH)) u_rdmux (
    .stage_q  (stage_q),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data)
  );

  assign dout = oe_n ? {WIDTH{1'bz}} : rd_data;

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    (HAS_RESET && rst) |=> (stage_q == '0));

  // R2
  shift_all_chk: assert property (@(posedge clk) disable iff (rst)
    ev_shift4 |=> (stage_q[0] == $past(din)) && (stage_q[1] == $past(stage_q[0]))
               && (stage_q[2] == $past(stage_q[1])) && (stage_q[3] == $past(stage_q[2])));

  // R3
  lower_pair_chk: assert property (@(posedge clk) disable iff (rst)
    ev_lower |=> (stage_q[2] == $past(din)) && (stage_q[3] == $past(stage_q[2]))
              && $stable(stage_q[0]) && $stable(stage_q[1]));

  // R4
  upper_pair_chk: assert property (@(posedge clk) disable iff (rst)
    ev_upper |=> (stage_q[0] == $past(din)) && (stage_q[1] == $past(stage_q[0]))
              && $stable(stage_q[2]) && $stable(stage_q[3]));

  // R5
  hold_all_chk: assert property (@(posedge clk) disable iff (rst)
    ev_hold |=> $stable(stage_q));

  // R6
  sel_last_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == 2'b00) |-> (rd_data == stage_q[3]));

  // R6
  sel_first_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == 2'b11) |-> (rd_data == stage_q[0]));
endmodule

// File: tb/pipe_bank4_tb.sv
`timescale 1ns/1ps
module pipe_bank4_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] din;
  logic [1:0]   op;
  logic [1:0]   rd_sel;
  logic         oe_n;
  wire  [W-1:0] dout;

  always #2.5 clk = ~clk;

  pipe_bank4 #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .din(din), .op(op),
    .rd_sel(rd_sel), .oe_n(oe_n), .dout(dout)
  );

  int vecs = 0;
  int miss = 0;
  int unsigned seed = 32'h1234_5678;
  logic [W-1:0] model [4];   // model[0] = stage 1

  function automatic logic [W-1:0] expect_out();
    if (oe_n) return {W{1'bz}};
    case (rd_sel)
      2'b00:   return model[3];
      2'b01:   return model[2];
      2'b10:   return model[1];
      default: return model[0];
    endcase
  endfunction

  function automatic int unsigned next_rand(input int unsigned s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  // Called at a falling edge: drive, take the rising edge, update the
  // model, then compare at the next falling edge.
  task automatic step(input logic r, input logic [1:0] o, input logic [1:0] s,
                      input logic e, input logic [W-1:0] d, input string tag);
    logic [W-1:0] exp_v;
    rst = r; op = o; rd_sel = s; oe_n = e; din = d;
    @(posedge clk);
    if (r) begin
      foreach (model[k]) model[k] = '0;
    end else begin
      case (o)
        2'b00: begin model[3] = model[2]; model[2] = model[1]; model[1] = model[0]; model[0] = d; end
        2'b01: begin model[3] = model[2]; model[2] = d; end
        2'b10: begin model[1] = model[0]; model[0] = d; end
        default: ;
      endcase
    end
    @(negedge clk);
    exp_v = expect_out();
    vecs++;
    if (dout !== exp_v) begin
      miss++;
      $display("FAIL %s: op=%b sel=%b oe_n=%b dout=%h expected=%h", tag, o, s, e, dout, exp_v);
    end
  endtask

  // Reads all four stages with op=11 (R5, R6, R9).
  task automatic sweep(input string tag);
    for (int s = 0; s < 4; s++) step(1'b0, 2'b11, 2'(s), 1'b0, 16'hDEAD, tag);
  endtask

  initial begin
    #200000;
    miss++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    foreach (model[k]) model[k] = '0;
    rst = 1'b1; op = 2'b00; rd_sel = 2'b00; oe_n = 1'b0; din = 16'hFFFF;
    @(negedge clk);
    // R1: reset clears, even with a shift code present
    step(1'b1, 2'b00, 2'b00, 1'b0, 16'hFFFF, "R1 reset state");
    for (int s = 0; s < 4; s++) step(1'b1, 2'b00, 2'(s), 1'b0, 16'hA5A5, "R1 reset state");

    // R2 and R8: fill by full shift, reading stage 1 as it is written
    for (int i = 0; i < 4; i++) step(1'b0, 2'b00, 2'b11, 1'b0, 16'h1111 * 16'(i + 1), "R2 R8 shift");
    sweep("R2 R6 after shift");
    // R8: the last stage shows the value moved in on the same edge
    for (int i = 0; i < 3; i++) step(1'b0, 2'b00, 2'b00, 1'b0, 16'h0F00 + 16'(i), "R2 R8 tail");

    // R3: lower pair only
    for (int i = 0; i < 3; i++) step(1'b0, 2'b01, 2'b01, 1'b0, 16'hC000 + 16'(i), "R3 lower pair");
    sweep("R3 R6 after lower");

    // R4: upper pair only
    for (int i = 0; i < 3; i++) step(1'b0, 2'b10, 2'b10, 1'b0, 16'hB000 + 16'(i), "R4 upper pair");
    sweep("R4 R6 after upper");

    // R5: hold with changing input
    for (int i = 0; i < 4; i++) step(1'b0, 2'b11, 2'(i), 1'b0, 16'(i * 16'h3333), "R5 hold");

    // R7 and R9: toggle enable during hold, then confirm contents
    for (int i = 0; i < 8; i++) step(1'b0, 2'b11, 2'(i), 1'(i % 2), 16'h7777, "R7 R9 enable");
    sweep("R9 contents kept");
    // R7: high-impedance while a shift happens
    for (int i = 0; i < 4; i++) step(1'b0, 2'b00, 2'(i), 1'b1, 16'h9000 + 16'(i), "R7 hi-z");
    sweep("R7 R2 after hi-z shift");

    // Mixed back-to-back codes (R2 R3 R4 R5 R6 R7)
    for (int i = 0; i < 600; i++) begin
      seed = next_rand(seed);
      step(1'b0, seed[17:16], seed[21:20], (seed[27:24] == 4'hF), seed[15:0], "R2-mix R6 R7");
    end

    // R1: reset wins over a shift code in mid-run
    step(1'b1, 2'b00, 2'b11, 1'b0, 16'hBEEF, "R1 mid reset");
    sweep("R1 cleared");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule